// File: doc/BRIEF.md
# Timed-Unlock Storage Write Controller

This block sits on a byte-wide register bus. It guards writes to a small on-chip data store. Software loads a storage address, split into a high byte and a low byte, and a data byte. It then commits the data byte with two separate control writes. The first control write raises an arm bit. A start write that lands while the arm bit is still up commits the byte. The arm bit drops by itself a few clocks after it is raised. A slow or merged sequence is therefore discarded without any error. After a write is accepted, the start bit stays high as a busy flag for a fixed, parameterised number of clocks. Software polls that flag before it begins its next access.

Reads use a strobe bit in the control register. The strobe copies the byte at the current address into the data register, where software then reads it. The store is a register array that comes up as all ones after reset.

Top module: `tuc_nv_write_ctrl`

## Requirements
- R1: After the synchronous reset, the control, data, address-low and address-high registers all read 0x00, and every storage byte reads 0xFF.
- R2: The register index selects as follows: 0 is control, 1 is data, 2 is address low, 3 is address high. A control write with bit 2 set raises the arm bit, and bit 2 of the control register reads 1 for exactly ARM_WINDOW (4) cycles after that write's clock edge. It then reads 0 without any further write.
- R3: A control write with bit 1 set, without bit 2, that lands 1 to 4 cycles after the arm write writes the data register into storage at the current address. It also clears the arm bit.
- R4: A control write with bit 1 set while the arm bit reads 0 has no effect. This covers a start that was never armed and a start 5 or more cycles after the arm write. The busy bit stays 0 and storage is unchanged.
- R5: A single control write with bit 1 and bit 2 both set arms the block but commits nothing. The control register reads 0x04 afterwards.
- R6: After a commit, control bit 1 reads 1 for exactly BUSY_CYCLES cycles and then returns to 0 on its own.
- R7: A control write with bit 0 set, while not busy, loads the storage byte at the current address into the data register. Control bit 0 always reads 0.
- R8: While busy, writes to the data and address registers, control writes (arm, start or read strobe) are all ignored.
- R9: The effective address is the low byte joined with the lowest ADDR_W-8 bits of the high byte. Higher bits of the high byte are dropped and read back as 0.
- R10: A control write that commits ignores its own read-strobe bit, so the data register keeps the byte that was written.
- R11: An arm write while the arm bit is already set restarts the 4-cycle window from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe for one cycle |
| reg_sel | input | 2 | Register index (0 control, 1 data, 2 address low, 3 address high) |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Read byte of the selected register (combinational) |

## Verification
Two events can fall in the same cycle. The arm window can expire on the very edge where the start write lands, and a start can share one control write with the read strobe. The bench places a start exactly 4 cycles after the arm write and expects a commit. It places another 5 cycles after and expects storage to stay untouched. It also issues a combined start-and-read write, then judges the result from the data register and from later storage contents read at the ports.

// File: rtl/tuc_pkg.sv
package tuc_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_DATA    = 2'd1,
        SEL_ADDR_LO = 2'd2,
        SEL_ADDR_HI = 2'd3
    } reg_sel_e;

    localparam int CTL_RD  = 0;
    localparam int CTL_GO  = 1;
    localparam int CTL_ARM = 2;

    typedef struct packed {
        logic              data_wr;
        logic              alo_wr;
        logic              ahi_wr;
        logic              rd_req;
        logic              go_req;
        logic              arm_req;
        logic [BYTE_W-1:0] wbyte;
    } bus_cmd_t;

    function automatic logic [BYTE_W-1:0] ctrl_image(input logic armed, input logic busy);
        logic [BYTE_W-1:0] img;
        img          = '0;
        img[CTL_ARM] = armed;
        img[CTL_GO]  = busy;
        return img;
    endfunction

endpackage

// File: rtl/tuc_bus_decode.sv
module tuc_bus_decode
    import tuc_pkg::*;
(
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic              busy,
    output bus_cmd_t          cmd
);
    always_comb begin
        cmd       = '0;
        cmd.wbyte = reg_wdata;
        if (reg_we && !busy) begin
            case (reg_sel_e'(reg_sel))
                SEL_CTRL: begin
                    cmd.rd_req  = reg_wdata[CTL_RD];
                    cmd.go_req  = reg_wdata[CTL_GO];
                    cmd.arm_req = reg_wdata[CTL_ARM];
                end
                SEL_DATA:    cmd.data_wr = 1'b1;
                SEL_ADDR_LO: cmd.alo_wr  = 1'b1;
                SEL_ADDR_HI: cmd.ahi_wr  = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tuc_arm_window.sv
module tuc_arm_window #(
    parameter int ARM_WINDOW = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_set,
    input  logic consume,
    output logic armed
);
    localparam int CW = $clog2(ARM_WINDOW + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed  <= 1'b0;
            left_q <= '0;
        end else if (arm_set) begin
            armed  <= 1'b1;
            left_q <= CW'(ARM_WINDOW);
        end else if (consume) begin
            armed  <= 1'b0;
            left_q <= '0;
        end else if (armed) begin
            if (left_q == CW'(1)) armed <= 1'b0;
            left_q <= left_q - CW'(1);
        end
    end
endmodule

// File: rtl/tuc_busy_timer.sv
module tuc_busy_timer #(
    parameter int BUSY_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            left_q <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            left_q <= CW'(BUSY_CYCLES);
        end else if (busy) begin
            if (left_q == CW'(1)) busy <= 1'b0;
            left_q <= left_q - CW'(1);
        end
    end
endmodule

// File: rtl/tuc_store.sv
module tuc_store
    import tuc_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/tuc_nv_write_ctrl.sv
module tuc_nv_write_ctrl
    import tuc_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int BUSY_CYCLES = 16,
    parameter int ARM_WINDOW  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata
);
    localparam int HI_W = (ADDR_W > BYTE_W) ? ADDR_W - BYTE_W : 1;

    bus_cmd_t          cmd;
    logic              armed;
    logic              busy;
    logic              commit;
    logic              read_do;
    logic [BYTE_W-1:0] data_q;
    logic [BYTE_W-1:0] addr_lo_q;
    logic [BYTE_W-1:0] addr_hi_rd;
    logic [ADDR_W-1:0] eff_addr;
    logic [BYTE_W-1:0] store_rdata;

    tuc_bus_decode u_dec (
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .cmd       (cmd)
    );

    // a start counts only when the arm came from an earlier write
    assign commit  = cmd.go_req && !cmd.arm_req && armed;
    assign read_do = cmd.rd_req && !commit;

    tuc_arm_window #(.ARM_WINDOW(ARM_WINDOW)) u_arm (
        .clk     (clk),
        .rst     (rst),
        .arm_set (cmd.arm_req),
        .consume (commit),
        .armed   (armed)
    );

    tuc_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst   (rst),
        .start (commit),
        .busy  (busy)
    );

    always_ff @(posedge clk) begin
        if (rst)             addr_lo_q <= '0;
        else if (cmd.alo_wr) addr_lo_q <= cmd.wbyte;
    end

    generate
        if (ADDR_W > BYTE_W) begin : g_hi
            logic [HI_W-1:0] addr_hi_q;
            always_ff @(posedge clk) begin
                if (rst)             addr_hi_q <= '0;
                else if (cmd.ahi_wr) addr_hi_q <= cmd.wbyte[HI_W-1:0];
            end
            assign addr_hi_rd = BYTE_W'(addr_hi_q);
            assign eff_addr   = {addr_hi_q, addr_lo_q};
        end else begin : g_lo_only
            assign addr_hi_rd = '0;
            assign eff_addr   = addr_lo_q[ADDR_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)              data_q <= '0;
        else if (cmd.data_wr) data_q <= cmd.wbyte;
        else if (read_do)     data_q <= store_rdata;
    end

    tuc_store #(.ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (commit),
        .addr  (eff_addr),
        .wdata (data_q),
        .rdata (store_rdata)
    );

    always_comb begin
        case (reg_sel_e'(reg_sel))
            SEL_CTRL:    reg_rdata = ctrl_image(armed, busy);
            SEL_DATA:    reg_rdata = data_q;
            SEL_ADDR_LO: reg_rdata = addr_lo_q;
            default:     reg_rdata = addr_hi_rd;
        endcase
    end
endmodule

// File: rtl/tuc_nv_write_chk.sv
module tuc_nv_write_chk #(
    parameter int BUSY_CYCLES = 16,
    parameter int ARM_WINDOW  = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       reg_we,
    input logic [1:0] reg_sel,
    input logic       wr_go,
    input logic       wr_arm,
    input logic       rd_go,
    input logic       rd_strobe,
    input logic       armed,
    input logic       busy,
    input logic [7:0] addr_lo
);
    logic        ctrl_wr;
    logic [7:0]  arm_age;
    logic [31:0] busy_age;

    assign ctrl_wr = reg_we && (reg_sel == 2'd0) && !busy;

    always_ff @(posedge clk) begin
        if (rst)                    arm_age <= '0;
        else if (ctrl_wr && wr_arm) arm_age <= 8'd1;
        else if (armed)             arm_age <= arm_age + 8'd1;
        else                        arm_age <= '0;
    end

    always_ff @(posedge clk) begin
        if (rst)       busy_age <= '0;
        else if (busy) busy_age <= busy_age + 32'd1;
        else           busy_age <= '0;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!armed && !busy)) else $error("reset state");                // R1
    AST_ARM_WINDOW: assert property (@(posedge clk) disable iff (rst)
        armed |-> (arm_age <= 8'(ARM_WINDOW))) else $error("arm window");            // R2
    AST_GO_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(armed)) else $error("commit without arm");              // R4
    AST_MERGED_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wr_arm && wr_go) |=> !busy) else $error("merged write");          // R5
    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_age < 32'(BUSY_CYCLES))) else $error("busy length");           // R6
    AST_BUSY_READBACK: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == 2'd0) |-> (rd_go == busy)) else $error("busy readback");          // R6
    AST_STROBE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == 2'd0) |-> !rd_strobe) else $error("strobe readback");             // R7
    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_we && reg_sel == 2'd2) |=> $stable(addr_lo)) else $error("addr frozen"); // R8
endmodule

bind tuc_nv_write_ctrl tuc_nv_write_chk #(
    .BUSY_CYCLES (BUSY_CYCLES),
    .ARM_WINDOW  (ARM_WINDOW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .wr_go     (reg_wdata[1]),
    .wr_arm    (reg_wdata[2]),
    .rd_go     (reg_rdata[1]),
    .rd_strobe (reg_rdata[0]),
    .armed     (armed),
    .busy      (busy),
    .addr_lo   (addr_lo_q)
);

// File: tb/tuc_nv_write_ctrl_test.sv
`timescale 1ns/1ps
module tuc_nv_write_ctrl_test;
    localparam int AW   = 9;
    localparam int BUSY = 16;
    localparam int WIN  = 4;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
        logic [7:0] dat;
        logic [2:0] gap;
        logic       ok;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'h00, 8'h05, 8'hA5, 3'd1, 1'b1},
        '{8'h01, 8'h05, 8'h3C, 3'd2, 1'b1},
        '{8'h00, 8'h10, 8'h11, 3'd3, 1'b1},
        '{8'h00, 8'hFF, 8'h22, 3'd4, 1'b1},
        '{8'h00, 8'h20, 8'h99, 3'd5, 1'b0},
        '{8'h01, 8'hFF, 8'h00, 3'd4, 1'b1},
        '{8'h00, 8'h05, 8'h5A, 3'd6, 1'b0},
        '{8'h00, 8'h05, 8'hC3, 3'd1, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [7:0] model [1 << AW];

    always #2.5 clk = ~clk;

    tuc_nv_write_ctrl #(.ADDR_W(AW), .BUSY_CYCLES(BUSY), .ARM_WINDOW(WIN)) uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog (all requirements) act=%0d cycles exp=<100000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%02h exp=%02h", req, act, exp);
        end
    endtask

    // called at a negedge; the write lands on the next posedge
    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] v);
        reg_sel = sel;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic busy_cycles(output int n);
        logic [7:0] v;
        n = 0;
        rd(2'd0, v);
        while (v[1] && n < 1000) begin
            n++;
            @(negedge clk);
            rd(2'd0, v);
        end
    endtask

    task automatic strobe_read(input logic [7:0] hi, input logic [7:0] lo, output logic [7:0] v);
        wr(2'd3, hi);
        wr(2'd2, lo);
        wr(2'd0, 8'h01);
        rd(2'd1, v);
    endtask

    initial begin
        logic [7:0] v;
        int n;
        int a;
        for (int i = 0; i < (1 << AW); i++) model[i] = 8'hFF;
        idle(3);
        rst = 1'b0;

        // R1: reset values
        rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
        rd(2'd1, v); chk("R1 data", v, 8'h00);
        rd(2'd2, v); chk("R1 addr lo", v, 8'h00);
        rd(2'd3, v); chk("R1 addr hi", v, 8'h00);
        strobe_read(8'h01, 8'hAB, v); chk("R1 R7 storage init", v, 8'hFF);

        // vector table: R3 commit inside window, R4 late start
        foreach (VECS[k]) begin
            a = int'({VECS[k].hi[0], VECS[k].lo});
            wr(2'd3, VECS[k].hi);
            wr(2'd2, VECS[k].lo);
            wr(2'd1, VECS[k].dat);
            wr(2'd0, 8'h04);
            idle(int'(VECS[k].gap) - 1);
            wr(2'd0, 8'h02);
            rd(2'd0, v);
            chk(VECS[k].ok ? "R3 busy after timed start" : "R4 late start ignored",
                v, VECS[k].ok ? 8'h02 : 8'h00);
            busy_cycles(n);
            if (VECS[k].ok) model[a] = VECS[k].dat;
            strobe_read(VECS[k].hi, VECS[k].lo, v);
            chk("R3 R4 R9 storage readback", v, model[a]);
        end

        // R9: high byte keeps only its lowest ADDR_W-8 bits
        wr(2'd3, 8'hFF);
        rd(2'd3, v); chk("R9 hi mask", v, 8'h01);

        // R2: arm visible exactly 4 cycles
        wr(2'd0, 8'h04);
        for (int c = 1; c <= 5; c++) begin
            rd(2'd0, v);
            chk("R2 arm bit window", v, (c <= WIN) ? 8'h04 : 8'h00);
            idle(1);
        end

        // R4: start never armed
        wr(2'd2, 8'h40); wr(2'd3, 8'h00); wr(2'd1, 8'h12);
        wr(2'd0, 8'h02);
        rd(2'd0, v); chk("R4 unarmed start", v, 8'h00);
        strobe_read(8'h00, 8'h40, v); chk("R4 storage unchanged", v, model[16'h040]);

        // R5: merged arm+start
        wr(2'd1, 8'h34);
        wr(2'd0, 8'h06);
        rd(2'd0, v); chk("R5 merged write arms only", v, 8'h04);
        idle(6);
        strobe_read(8'h00, 8'h40, v); chk("R5 storage unchanged", v, model[16'h040]);

        // R6 + R8: busy length and ignored accesses
        wr(2'd1, 8'h5D);
        wr(2'd0, 8'h04);
        wr(2'd0, 8'h02);
        model[16'h040] = 8'h5D;
        wr(2'd1, 8'h77);
        wr(2'd2, 8'h33);
        wr(2'd0, 8'h01);
        wr(2'd0, 8'h04);
        rd(2'd1, v); chk("R8 data write ignored", v, 8'h5D);
        rd(2'd2, v); chk("R8 addr write ignored", v, 8'h40);
        rd(2'd0, v); chk("R8 ctrl write ignored", v, 8'h02);
        busy_cycles(n);
        chk("R6 busy length", 8'(n + 4), 8'(BUSY));
        strobe_read(8'h00, 8'h40, v); chk("R6 committed byte", v, 8'h5D);

        // R10: start and read strobe in one committing write
        wr(2'd2, 8'h41);
        wr(2'd1, 8'h6E);
        wr(2'd0, 8'h04);
        wr(2'd0, 8'h03);
        model[16'h041] = 8'h6E;
        rd(2'd1, v); chk("R10 read bit ignored on commit", v, 8'h6E);
        busy_cycles(n);
        strobe_read(8'h00, 8'h41, v); chk("R10 storage", v, 8'h6E);

        // R11: re-arm restarts the window
        wr(2'd2, 8'h42);
        wr(2'd1, 8'h19);
        wr(2'd0, 8'h04);
        idle(2);
        wr(2'd0, 8'h04);
        idle(3);
        wr(2'd0, 8'h02);
        rd(2'd0, v); chk("R11 rearm commit", v, 8'h02);
        busy_cycles(n);
        strobe_read(8'h00, 8'h42, v); chk("R11 storage", v, 8'h19);

        summary();
        $finish;
    end
endmodule